// File: doc/BRIEF.md
# Transmit AIS Insertion Controller

This block sits at the transmit end of a primary-rate line and decides, bit by bit, whether the line carries the user's data or the Alarm Indication Signal. AIS is an all-ones stream with no framing, so every bit position is forced to 1 while it is active. Everything runs on one fast reference clock. The primary and alternate bit clocks arrive as single-cycle strobes sampled on that clock.

There are three triggers. The first is a manual request. The second is loss of the primary transmit clock, which counts only when the alternate timing source is enabled. The third is a receive-side loss flag, armed by the automatic-AIS enable. The interface-type select decides which receive flag counts. During line loopback, either receive flag counts, so that a keep-alive signal continues to reach the far end. When the alternate source is enabled, AIS bits are paced by the alternate strobe. Normal data is always paced by the primary strobe. A built-in watchdog declares transmit loss of clock. Status outputs show that watchdog and the cause of AIS.

Top module: `tx_ais_ctrl`

## Requirements
- R1: After reset, `line_bit`, `line_stb`, `tx_loc`, `ais_active` and `ais_cause` are all 0.
- R2: Without AIS, a primary strobe sampled at a clock edge makes `line_stb` 1 for that one cycle, and `line_bit` takes the `tx_bit` value sampled at the same edge.
- R3: While `ais_active` is 1, every emitted bit is 1 regardless of `tx_bit`. A manual request is enough to start AIS.
- R4: `tx_loc` rises after 64 consecutive reference edges without a primary strobe. It clears at the edge that samples the next primary strobe.
- R5: Transmit loss of clock triggers AIS only when `alt_clk_en` is 1. With `alt_clk_en` 0, it leaves `ais_cause` at 0.
- R6: When AIS is requested with `alt_clk_en` set, bits are emitted only on alternate strobes, and primary strobes produce no `line_stb`. With no AIS requested, alternate strobes produce no `line_stb`.
- R7: With `auto_ais_en` set and loopback off, `rx_los` triggers when `dig_if_sel` is 0 (analog) and `rx_loc` triggers when it is 1 (digital). The other flag is ignored.
- R8: With `auto_ais_en` and `line_lpbk` both set, either receive flag triggers AIS, whatever `dig_if_sel` is.
- R9: With `auto_ais_en` clear, the receive flags have no effect.
- R10: `ais_cause` is one-hot, with priority manual (bit 0) over transmit clock loss (bit 1) over receive loss (bit 2). It is 0 when nothing is requested. It follows the inputs one clock after they change.
- R11: Switching between data and AIS happens only at an emitted strobe. Between strobes, `line_bit` and `ais_active` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pri_stb | input | 1 | Primary transmit bit strobe |
| alt_stb | input | 1 | Alternate bit strobe |
| tx_bit | input | 1 | Transmit data bit |
| ais_manual | input | 1 | Manual AIS request |
| alt_clk_en | input | 1 | Use the alternate source for AIS and arm the clock-loss trigger |
| auto_ais_en | input | 1 | Arm the receive-loss trigger |
| rx_los | input | 1 | Receive loss of signal |
| rx_loc | input | 1 | Receive loss of clock |
| dig_if_sel | input | 1 | 1 selects the digital line interface |
| line_lpbk | input | 1 | Line loopback active |
| line_bit | output | 1 | Transmitted line bit |
| line_stb | output | 1 | Strobe marking a new line bit |
| tx_loc | output | 1 | Transmit loss of clock |
| ais_active | output | 1 | The last emitted bit was AIS |
| ais_cause | output | 3 | One-hot AIS cause |

## Verification
A trigger input reaches `ais_cause` one clock edge after it changes. It reaches `line_bit` and `ais_active` only at the first strobe edge of the selected source after that. Strobed outputs appear right after the edge that samples the strobe, and `line_stb` drops one edge later. The bench drives on the falling edge and samples on the next falling edge, so each check reads exactly the cycle these counts predict. Between strobes, the bench checks that the line holds its value. Each check on `tx_loc` is placed by counting 63 and then 64 strobe-free edges after a primary strobe.

// File: rtl/tx_ais_ctrl.sv
module tx_ais_ctrl #(
  parameter int LOC_LIMIT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pri_stb,
  input  logic       alt_stb,
  input  logic       tx_bit,
  input  logic       ais_manual,
  input  logic       alt_clk_en,
  input  logic       auto_ais_en,
  input  logic       rx_los,
  input  logic       rx_loc,
  input  logic       dig_if_sel,
  input  logic       line_lpbk,
  output logic       line_bit,
  output logic       line_stb,
  output logic       tx_loc,
  output logic       ais_active,
  output logic [2:0] ais_cause
);
  localparam int CW = $clog2(LOC_LIMIT + 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(LOC_LIMIT - 1);

  logic [CW-1:0] gap_cnt;
  logic man_q, loc_q, rx_q;
  logic rx_loss, ais_req, tgt_alt, pick_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      tx_loc  <= 1'b0;
    end else if (pri_stb) begin
      gap_cnt <= '0;
      tx_loc  <= 1'b0;
    end else if (gap_cnt == GAP_LAST) begin
      tx_loc  <= 1'b1;
    end else begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assign rx_loss = auto_ais_en &
                   (line_lpbk ? (rx_los | rx_loc) : (dig_if_sel ? rx_loc : rx_los));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man_q <= 1'b0;
      loc_q <= 1'b0;
      rx_q  <= 1'b0;
    end else begin
      man_q <= ais_manual;
      loc_q <= alt_clk_en & tx_loc;
      rx_q  <= rx_loss;
    end
  end

  assign ais_req  = man_q | loc_q | rx_q;
  assign tgt_alt  = ais_req & alt_clk_en;
  assign pick_stb = tgt_alt ? alt_stb : pri_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_bit   <= 1'b0;
      line_stb   <= 1'b0;
      ais_active <= 1'b0;
    end else begin
      line_stb <= pick_stb;
      if (pick_stb) begin
        ais_active <= ais_req;
        line_bit   <= ais_req | tx_bit;
      end
    end
  end

  assign ais_cause = man_q ? 3'b001 :
                     loc_q ? 3'b010 :
                     rx_q  ? 3'b100 : 3'b000;
endmodule

// File: rtl/tx_ais_ctrl_chk.sv
module tx_ais_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pri_stb,
  input logic       alt_stb,
  input logic       line_bit,
  input logic       line_stb,
  input logic       tx_loc,
  input logic       ais_active,
  input logic [2:0] ais_cause
);
  // R3
  ais_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ais_active |-> line_bit);

  // R11
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |-> ($stable(line_bit) && $stable(ais_active)));

  // R10
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ais_cause));

  // R4
  loc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_loc) |-> $past(!pri_stb));

  // R4
  loc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pri_stb |=> !tx_loc);

  // R2
  stb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |-> ($past(pri_stb) || $past(alt_stb)));

  // R6
  data_on_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !ais_active) |-> $past(pri_stb));
endmodule

bind tx_ais_ctrl tx_ais_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pri_stb(pri_stb), .alt_stb(alt_stb),
  .line_bit(line_bit), .line_stb(line_stb), .tx_loc(tx_loc),
  .ais_active(ais_active), .ais_cause(ais_cause)
);

// File: tb/tx_ais_ctrl_tb.sv
module tx_ais_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pri_stb = 0, alt_stb = 0, tx_bit = 0, ais_manual = 0, alt_clk_en = 0;
  logic auto_ais_en = 0, rx_los = 0, rx_loc = 0, dig_if_sel = 0, line_lpbk = 0;
  logic line_bit, line_stb, tx_loc, ais_active;
  logic [2:0] ais_cause;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tx_ais_ctrl u_dut (.*);

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pstrobe(input logic b);
    tx_bit = b; pri_stb = 1'b1; @(negedge clk); pri_stb = 1'b0;
  endtask

  task automatic astrobe(input logic b);
    tx_bit = b; alt_stb = 1'b1; @(negedge clk); alt_stb = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 line_bit", {3'b0, line_bit}, 4'd0);
    chk("R1 line_stb", {3'b0, line_stb}, 4'd0);
    chk("R1 tx_loc", {3'b0, tx_loc}, 4'd0);
    chk("R1 ais_active", {3'b0, ais_active}, 4'd0);
    chk("R1 cause", {1'b0, ais_cause}, 4'd0);
  endtask

  task automatic t_normal;
    pstrobe(1'b1);
    chk("R2 stb", {3'b0, line_stb}, 4'd1);
    chk("R2 bit1", {3'b0, line_bit}, 4'd1);
    pstrobe(1'b0);
    chk("R2 bit0", {3'b0, line_bit}, 4'd0);
    tx_bit = 1'b1; tick(1);
    chk("R2 stb drop", {3'b0, line_stb}, 4'd0);
    chk("R11 hold bit", {3'b0, line_bit}, 4'd0);
  endtask

  task automatic t_manual;
    ais_manual = 1'b1; tick(1);
    chk("R10 manual cause", {1'b0, ais_cause}, 4'b0001);
    chk("R11 no switch before strobe", {3'b0, ais_active}, 4'd0);
    pstrobe(1'b0);
    chk("R3 ones", {3'b0, line_bit}, 4'd1);
    chk("R3 active", {3'b0, ais_active}, 4'd1);
    ais_manual = 1'b0; tick(2);
    chk("R11 hold ais", {3'b0, ais_active}, 4'd1);
    pstrobe(1'b0);
    chk("R3 back to data", {2'b0, ais_active, line_bit}, 4'd0);
  endtask

  task automatic t_loc;
    pstrobe(1'b0);
    tick(63);
    chk("R4 not yet", {3'b0, tx_loc}, 4'd0);
    tick(1);
    chk("R4 declared", {3'b0, tx_loc}, 4'd1);
    tick(1);
    chk("R5 no trigger w/o alt", {1'b0, ais_cause}, 4'd0);
    astrobe(1'b0);
    chk("R6 alt ignored for data", {3'b0, line_stb}, 4'd0);
    alt_clk_en = 1'b1; tick(1);
    chk("R5 loc cause", {1'b0, ais_cause}, 4'b0010);
    astrobe(1'b0);
    chk("R6 alt strobe emits ais", {1'b0, line_stb, ais_active, line_bit}, 4'b0111);
    pstrobe(1'b0);
    chk("R4 cleared", {3'b0, tx_loc}, 4'd0);
    chk("R6 pri ignored in ais", {3'b0, line_stb}, 4'd0);
    tick(1);
    chk("R5 cause cleared", {1'b0, ais_cause}, 4'd0);
    pstrobe(1'b0);
    chk("R11 back to data", {2'b0, ais_active, line_bit}, 4'd0);
    ais_manual = 1'b1; tick(1);
    pstrobe(1'b0);
    chk("R6 manual pri ignored", {3'b0, line_stb}, 4'd0);
    astrobe(1'b0);
    chk("R6 manual on alt", {2'b0, line_stb, line_bit}, 4'b0011);
    ais_manual = 1'b0; alt_clk_en = 1'b0; tick(1);
    pstrobe(1'b0);
    chk("R6 data resumes on pri", {1'b0, line_stb, ais_active, line_bit}, 4'b0100);
  endtask

  task automatic t_auto;
    auto_ais_en = 1'b1; dig_if_sel = 1'b0;
    rx_loc = 1'b1; tick(1);
    chk("R7 analog ignores loc", {1'b0, ais_cause}, 4'd0);
    rx_loc = 1'b0; rx_los = 1'b1; tick(1);
    chk("R7 analog los", {1'b0, ais_cause}, 4'b0100);
    pstrobe(1'b0);
    chk("R7 rx ais on line", {2'b0, ais_active, line_bit}, 4'b0011);
    dig_if_sel = 1'b1; tick(1);
    chk("R7 digital ignores los", {1'b0, ais_cause}, 4'd0);
    rx_los = 1'b0; rx_loc = 1'b1; tick(1);
    chk("R7 digital loc", {1'b0, ais_cause}, 4'b0100);
    dig_if_sel = 1'b0; line_lpbk = 1'b1; tick(1);
    chk("R8 loopback loc", {1'b0, ais_cause}, 4'b0100);
    rx_loc = 1'b0; rx_los = 1'b1; dig_if_sel = 1'b1; tick(1);
    chk("R8 loopback los", {1'b0, ais_cause}, 4'b0100);
    ais_manual = 1'b1; tick(1);
    chk("R10 manual over rx", {1'b0, ais_cause}, 4'b0001);
    ais_manual = 1'b0; tick(1);
    chk("R10 rx after manual", {1'b0, ais_cause}, 4'b0100);
    auto_ais_en = 1'b0; rx_loc = 1'b1; tick(1);
    chk("R9 auto off", {1'b0, ais_cause}, 4'd0);
    pstrobe(1'b0);
    chk("R9 data on line", {2'b0, ais_active, line_bit}, 4'd0);
    rx_los = 0; rx_loc = 0; line_lpbk = 0; dig_if_sel = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(2);
    t_reset();
    rst_n = 1'b1;
    tick(1);
    t_normal();
    t_manual();
    t_loc();
    t_auto();
    tick(2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule